// File: doc/BRIEF.md
# Split Read-Line and Write-Drain Buffer

This block sits between a burst-capable initiator and memory. Reads and writes take separate paths that share no state. A read request names a word address and a burst length. If the 256-bit line that holds that word is already loaded, the beats come straight out of the stored line. Otherwise the block first fetches the whole line from a 32-byte-aligned address, and the beats are served from it afterwards. A write is a single beat. It goes into a small first-in first-out buffer and later drains to memory, one entry for each grant.

The two buffers are independent on purpose. A read never picks up data that is still waiting in the write buffer. A write never touches, refreshes or invalidates the stored read line. Nothing is marked dirty and nothing is written back. Memory has two ports: one port fetches a full line, and the other port drains single writes.

Top module: `split_rw_buffer`

## Requirements
- R1: A read whose line is not loaded raises exactly one line fetch. The fetch address is the request address with its low 5 bits cleared, and it is held until granted.
- R2: A read to a word in the loaded line raises no fetch. Its first beat is valid in the cycle right after the request is accepted.
- R3: A read with length field L (3 bits) returns L+1 beats, one per cycle with no gaps. Beat k is line word ((i+k) mod 8), where i is address bits [4:2]. The last-beat flag is high on the final beat only.
- R4: A read returns memory line data even when a write to the same address is still waiting in the write buffer.
- R5: A write does not change or invalidate the loaded line. A later read of that line is a hit and returns the original data.
- R6: The write buffer accepts writes while it holds fewer than 4 entries. With 4 entries it drops request-ready for writes.
- R7: Memory write requests are raised whenever the buffer holds data. Entries drain in arrival order with address and data unchanged, one per grant, and they stay stable while no grant is given.
- R8: Reset empties the write buffer and marks the line as not loaded, so the first read after reset fetches.
- R9: While a read is in progress, further reads are refused but writes are still accepted. A read is accepted while the write buffer is full.
- R10: On a fill, line word w is taken from bits [32w+31:32w] of the returned line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_req_valid | input | 1 | Request valid |
| s_req_ready | output | 1 | Request accepted this cycle when high with valid |
| s_req_write | input | 1 | 1 = single-beat write, 0 = burst read |
| s_req_addr | input | 32 | Byte address, word aligned |
| s_req_len | input | 3 | Read burst length minus one |
| s_req_wdata | input | 32 | Write data |
| s_rsp_valid | output | 1 | Read beat valid |
| s_rsp_data | output | 32 | Read beat data |
| s_rsp_last | output | 1 | Final beat of the burst |
| mem_rd_req | output | 1 | Line fetch request |
| mem_rd_addr | output | 32 | Line fetch address, 32-byte aligned |
| mem_rd_gnt | input | 1 | Line fetch accepted |
| mem_rd_valid | input | 1 | Fetched line present |
| mem_rd_line | input | 256 | Fetched line data |
| mem_wr_req | output | 1 | Write drain request |
| mem_wr_addr | output | 32 | Write drain address |
| mem_wr_data | output | 32 | Write drain data |
| mem_wr_gnt | input | 1 | Write drain accepted |

## Verification
The hardest case to reach is a read that targets an address whose write is still sitting in the write buffer. Reaching it requires memory to hold back write grants while the read is served. The bench withholds write grants, queues writes to addresses inside the loaded line and inside a line that is not loaded, and reads those addresses back as a hit and as a miss. It then releases the grants and checks the drain order. A read is also issued while the buffer is full, and a write is offered in the cycle after a read miss starts. These two cases show that each path keeps going while the other is stalled.

// File: rtl/split_rw_buffer_pkg.sv
// Shared definitions for the split read-line / write-drain buffer.
// Assumes nothing beyond the parameter defaults given here.
package split_rw_buffer_pkg;
    localparam int unsigned SRB_ADDR_W     = 32;
    localparam int unsigned SRB_BEAT_W     = 32;
    localparam int unsigned SRB_LINE_BEATS = 8;
    localparam int unsigned SRB_WB_DEPTH   = 4;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_FETCH = 2'd1,
        RD_WAIT  = 2'd2,
        RD_SERVE = 2'd3
    } rd_state_e;
endpackage

// File: rtl/rd_line_path.sv
// Read path: holds one line plus its tag. A hit serves beats from the stored
// line. A miss fetches the aligned line first and then serves the beats.
// Assumes: LINE_BEATS and BEAT_W/8 are powers of two, and memory returns a
// whole line in one cycle after granting the fetch.
module rd_line_path
    import split_rw_buffer_pkg::*;
#(
    parameter int unsigned ADDR_W     = SRB_ADDR_W,
    parameter int unsigned BEAT_W     = SRB_BEAT_W,
    parameter int unsigned LINE_BEATS = SRB_LINE_BEATS,
    localparam int unsigned BYTE_OFF  = $clog2(BEAT_W / 8),
    localparam int unsigned IDX_W     = $clog2(LINE_BEATS),
    localparam int unsigned LINE_OFF  = IDX_W + BYTE_OFF,
    localparam int unsigned TAG_W     = ADDR_W - LINE_OFF,
    localparam int unsigned WADDR_W   = ADDR_W - BYTE_OFF,
    localparam int unsigned LINE_W    = LINE_BEATS * BEAT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc,
    input  logic [WADDR_W-1:0]  acc_waddr,
    input  logic [IDX_W-1:0]    acc_len,
    output logic                idle,
    output logic                rsp_valid,
    output logic [BEAT_W-1:0]   rsp_data,
    output logic                rsp_last,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    input  logic                mem_rd_gnt,
    input  logic                mem_rd_valid,
    input  logic [LINE_W-1:0]   mem_rd_line
);
    rd_state_e               state_q;
    logic [BEAT_W-1:0]       line_q     [LINE_BEATS];
    logic [BEAT_W-1:0]       fill_words [LINE_BEATS];
    logic                    valid_q;
    logic [TAG_W-1:0]        tag_q;
    logic [TAG_W-1:0]        req_tag_q;
    logic [IDX_W-1:0]        idx_q;
    logic [IDX_W-1:0]        cnt_q;
    logic [IDX_W-1:0]        len_q;
    logic [TAG_W-1:0]        acc_tag;
    logic [IDX_W-1:0]        acc_idx;
    logic                    hit;

    // Split the incoming word address into line tag and word index.
    assign acc_tag = acc_waddr[WADDR_W-1:IDX_W];
    assign acc_idx = acc_waddr[IDX_W-1:0];
    assign hit     = valid_q && (tag_q == acc_tag);

    // Unpack the returned line into words, lowest word in the lowest bits.
    genvar g;
    generate
        for (g = 0; g < LINE_BEATS; g++) begin : g_unpack
            assign fill_words[g] = mem_rd_line[g*BEAT_W +: BEAT_W];
        end
    endgenerate

    // Sequence of the read path: idle, fetch, wait for line, serve beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RD_IDLE;
            valid_q   <= 1'b0;
            tag_q     <= '0;
            req_tag_q <= '0;
            idx_q     <= '0;
            cnt_q     <= '0;
            len_q     <= '0;
        end else begin
            case (state_q)
                RD_IDLE: begin
                    if (acc) begin
                        idx_q <= acc_idx;
                        len_q <= acc_len;
                        cnt_q <= '0;
                        if (hit) begin
                            state_q <= RD_SERVE;
                        end else begin
                            req_tag_q <= acc_tag;
                            valid_q   <= 1'b0;
                            state_q   <= RD_FETCH;
                        end
                    end
                end
                RD_FETCH: begin
                    if (mem_rd_gnt) begin
                        state_q <= RD_WAIT;
                    end
                end
                RD_WAIT: begin
                    if (mem_rd_valid) begin
                        valid_q <= 1'b1;
                        tag_q   <= req_tag_q;
                        state_q <= RD_SERVE;
                    end
                end
                default: begin
                    idx_q <= idx_q + IDX_W'(1);
                    cnt_q <= cnt_q + IDX_W'(1);
                    if (cnt_q == len_q) begin
                        state_q <= RD_IDLE;
                    end
                end
            endcase
        end
    end

    // Capture the fetched line; the data needs no reset since valid_q guards it.
    always_ff @(posedge clk) begin
        if ((state_q == RD_WAIT) && mem_rd_valid) begin
            line_q <= fill_words;
        end
    end

    // Drive the response and the fetch request from registered state.
    always_comb begin
        idle        = (state_q == RD_IDLE);
        rsp_valid   = (state_q == RD_SERVE);
        rsp_data    = line_q[idx_q];
        rsp_last    = (state_q == RD_SERVE) && (cnt_q == len_q);
        mem_rd_req  = (state_q == RD_FETCH);
        mem_rd_addr = {req_tag_q, {LINE_OFF{1'b0}}};
    end
endmodule

// File: rtl/wr_drain_fifo.sv
// Write path: a first-in first-out buffer of address/data pairs. It requests
// memory whenever it is not empty and pops one entry per grant.
// Assumes: DEPTH is a power of two; a grant while empty is ignored.
module wr_drain_fifo #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1,
    localparam int unsigned ENT_W = ADDR_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_gnt
);
    logic [ENT_W-1:0] store_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] level_q;
    logic             empty;
    logic             pop;

    // Occupancy flags and the pop condition.
    assign empty = (level_q == '0);
    assign full  = (level_q == CNT_W'(DEPTH));
    assign pop   = mem_wr_gnt && !empty;

    // Pointer and level bookkeeping, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            if (pop)  rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            case ({push, pop})
                2'b10:   level_q <= level_q + CNT_W'(1);
                2'b01:   level_q <= level_q - CNT_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    // Entry storage; the pointers decide which entries are live.
    always_ff @(posedge clk) begin
        if (push) begin
            store_q[wr_ptr_q] <= {push_addr, push_data};
        end
    end

    // Present the oldest entry to memory.
    always_comb begin
        mem_wr_req  = !empty;
        mem_wr_addr = store_q[rd_ptr_q][ENT_W-1:DATA_W];
        mem_wr_data = store_q[rd_ptr_q][DATA_W-1:0];
    end
endmodule

// File: rtl/split_rw_buffer.sv
// Top: one request port feeds either the read-line path or the write-drain
// buffer. The two share no state: no forwarding and no invalidation.
// Assumes word-aligned addresses and single-beat writes.
module split_rw_buffer
    import split_rw_buffer_pkg::*;
#(
    parameter int unsigned ADDR_W     = SRB_ADDR_W,
    parameter int unsigned BEAT_W     = SRB_BEAT_W,
    parameter int unsigned LINE_BEATS = SRB_LINE_BEATS,
    parameter int unsigned WB_DEPTH   = SRB_WB_DEPTH,
    localparam int unsigned BYTE_OFF  = $clog2(BEAT_W / 8),
    localparam int unsigned IDX_W     = $clog2(LINE_BEATS),
    localparam int unsigned LINE_W    = LINE_BEATS * BEAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req_valid,
    output logic              s_req_ready,
    input  logic              s_req_write,
    input  logic [ADDR_W-1:0] s_req_addr,
    input  logic [IDX_W-1:0]  s_req_len,
    input  logic [BEAT_W-1:0] s_req_wdata,
    output logic              s_rsp_valid,
    output logic [BEAT_W-1:0] s_rsp_data,
    output logic              s_rsp_last,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_gnt,
    input  logic              mem_rd_valid,
    input  logic [LINE_W-1:0] mem_rd_line,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BEAT_W-1:0] mem_wr_data,
    input  logic              mem_wr_gnt
);
    logic rd_idle;
    logic wb_full;
    logic rd_acc;
    logic wb_push;

    // Steer the request by direction; each path answers for itself.
    always_comb begin
        s_req_ready = s_req_write ? !wb_full : rd_idle;
        rd_acc      = s_req_valid && !s_req_write && rd_idle;
        wb_push     = s_req_valid &&  s_req_write && !wb_full;
    end

    rd_line_path #(
        .ADDR_W     (ADDR_W),
        .BEAT_W     (BEAT_W),
        .LINE_BEATS (LINE_BEATS)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (rd_acc),
        .acc_waddr    (s_req_addr[ADDR_W-1:BYTE_OFF]),
        .acc_len      (s_req_len),
        .idle         (rd_idle),
        .rsp_valid    (s_rsp_valid),
        .rsp_data     (s_rsp_data),
        .rsp_last     (s_rsp_last),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_gnt   (mem_rd_gnt),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_line  (mem_rd_line)
    );

    wr_drain_fifo #(
        .ADDR_W (ADDR_W),
        .DATA_W (BEAT_W),
        .DEPTH  (WB_DEPTH)
    ) u_wb (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (wb_push),
        .push_addr   (s_req_addr),
        .push_data   (s_req_wdata),
        .full        (wb_full),
        .mem_wr_req  (mem_wr_req),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_gnt  (mem_wr_gnt)
    );
endmodule

// File: rtl/split_rw_buffer_chk.sv
// Port-level temporal checks for split_rw_buffer, attached with bind.
module split_rw_buffer_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BEAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_req_write,
    input logic              s_req_ready,
    input logic              s_rsp_valid,
    input logic              s_rsp_last,
    input logic              mem_rd_req,
    input logic              mem_rd_gnt,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_wr_req,
    input logic              mem_wr_gnt,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [BEAT_W-1:0] mem_wr_data
);
    // R1: an ungranted fetch stays up with the same address.
    p_fetch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_gnt |=> mem_rd_req && $stable(mem_rd_addr));

    // R1: no beat can appear in the cycle after the fetch is granted.
    p_no_early_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && mem_rd_gnt |=> !s_rsp_valid);

    // R2: serving beats and fetching never overlap.
    p_no_fetch_when_serving_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid |-> !mem_rd_req);

    // R3: the last flag only comes with a valid beat.
    p_last_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_last |-> s_rsp_valid);

    // R3: beats are back to back until the last one.
    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid && !s_rsp_last |=> s_rsp_valid);

    // R7: a waiting write holds its address and data.
    p_drain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req && !mem_wr_gnt |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

    // R9: no read is taken while a burst is being served.
    p_read_refused_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_rsp_valid && !s_req_write |-> !s_req_ready);
endmodule

bind split_rw_buffer split_rw_buffer_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_req_write (s_req_write),
    .s_req_ready (s_req_ready),
    .s_rsp_valid (s_rsp_valid),
    .s_rsp_last  (s_rsp_last),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_gnt  (mem_rd_gnt),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_gnt  (mem_wr_gnt),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data)
);

// File: tb/test_split_rw_buffer.sv
`timescale 1ns/1ps
module test_split_rw_buffer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         s_req_valid, s_req_ready, s_req_write;
    logic [31:0]  s_req_addr, s_req_wdata;
    logic [2:0]   s_req_len;
    logic         s_rsp_valid, s_rsp_last;
    logic [31:0]  s_rsp_data;
    logic         mem_rd_req, mem_rd_gnt, mem_rd_valid;
    logic [31:0]  mem_rd_addr;
    logic [255:0] mem_rd_line;
    logic         mem_wr_req, mem_wr_gnt;
    logic [31:0]  mem_wr_addr, mem_wr_data;

    int n_tests = 0, n_fail = 0;
    int fetch_cnt = 0;
    logic [31:0] fetch_addr = '0;
    bit   wr_gnt_en = 1'b1;
    bit   pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [31:0] q_addr [64];
    logic [31:0] q_data [64];
    int q_head = 0, q_tail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    split_rw_buffer i_split_rw_buffer (
        .clk(clk), .rst_n(rst_n),
        .s_req_valid(s_req_valid), .s_req_ready(s_req_ready), .s_req_write(s_req_write),
        .s_req_addr(s_req_addr), .s_req_len(s_req_len), .s_req_wdata(s_req_wdata),
        .s_rsp_valid(s_rsp_valid), .s_rsp_data(s_rsp_data), .s_rsp_last(s_rsp_last),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_gnt(mem_rd_gnt),
        .mem_rd_valid(mem_rd_valid), .mem_rd_line(mem_rd_line),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_gnt(mem_wr_gnt)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'hA5A5_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Line memory model: grant a fetch, return the line one cycle later (R10 layout).
    initial begin
        mem_rd_gnt = 1'b0; mem_rd_valid = 1'b0; mem_rd_line = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pend) begin
                for (int w = 0; w < 8; w++)
                    mem_rd_line[w*32 +: 32] = mem_word(pend_addr + 32'(4*w));
                mem_rd_valid = 1'b1;
                pend = 1'b0;
            end
            if (rst_n && mem_rd_req && !mem_rd_gnt) begin
                mem_rd_gnt = 1'b1;
                fetch_cnt++;
                fetch_addr = mem_rd_addr;
                pend_addr = mem_rd_addr;
                pend = 1'b1;
            end else begin
                mem_rd_gnt = 1'b0;
            end
        end
    end

    // Write sink: grant when enabled, check arrival order (R7).
    initial begin
        mem_wr_gnt = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && wr_gnt_en && mem_wr_req) begin
                mem_wr_gnt = 1'b1;
                chk(q_head != q_tail, "R7 drain with nothing queued", 32'(q_tail - q_head), 32'd1);
                chk(mem_wr_addr == q_addr[q_head % 64], "R7 drain address order", mem_wr_addr, q_addr[q_head % 64]);
                chk(mem_wr_data == q_data[q_head % 64], "R7 drain data order", mem_wr_data, q_data[q_head % 64]);
                q_head++;
            end else begin
                mem_wr_gnt = 1'b0;
            end
        end
    end

    // Present a read and return at the negedge after it was accepted.
    task automatic rd_start(input logic [31:0] a, input logic [2:0] len);
        int guard = 0;
        s_req_valid = 1'b1; s_req_write = 1'b0; s_req_addr = a; s_req_len = len;
        #1;
        while (!s_req_ready && guard < 50) begin
            @(negedge clk); #1; guard++;
        end
        @(negedge clk);
        s_req_valid = 1'b0;
    endtask

    // Collect and check all beats of a burst (R2, R3, R1).
    task automatic rd_collect(input logic [31:0] a, input logic [2:0] len, input bit exp_hit, input int f0);
        int k = 0;
        int guard = 0;
        logic [31:0] base;
        int idx;
        base = a & ~32'h1F;
        idx  = int'(a[4:2]);
        if (exp_hit) chk(s_rsp_valid == 1'b1, "R2 first beat one cycle after accept", 32'(s_rsp_valid), 32'd1);
        while (k <= int'(len) && guard < 60) begin
            if (s_rsp_valid) begin
                chk(s_rsp_data == mem_word(base + 32'(4*((idx + k) % 8))), "R3 beat data",
                    s_rsp_data, mem_word(base + 32'(4*((idx + k) % 8))));
                chk(s_rsp_last == (k == int'(len)), "R3 last flag", 32'(s_rsp_last), 32'(k == int'(len)));
                k++;
            end else if (k > 0) begin
                chk(1'b0, "R3 gap between beats", 32'd0, 32'd1);
                k = 99;
            end
            @(negedge clk);
            guard++;
        end
        chk(k == int'(len) + 1, "R3 beat count", 32'(k), 32'(int'(len) + 1));
        chk(fetch_cnt - f0 == (exp_hit ? 0 : 1), exp_hit ? "R2 no fetch on hit" : "R1 one fetch on miss",
            32'(fetch_cnt - f0), exp_hit ? 32'd0 : 32'd1);
        if (!exp_hit) chk(fetch_addr == base, "R1 fetch address aligned", fetch_addr, base);
    endtask

    task automatic rd(input logic [31:0] a, input logic [2:0] len, input bit exp_hit);
        int f0;
        f0 = fetch_cnt;
        rd_start(a, len);
        rd_collect(a, len, exp_hit, f0);
    endtask

    // One write attempt; records it as expected drain traffic if accepted (R6).
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit exp_acc);
        s_req_valid = 1'b1; s_req_write = 1'b1; s_req_addr = a; s_req_wdata = d;
        #1;
        chk(s_req_ready == exp_acc, "R6 write ready", 32'(s_req_ready), 32'(exp_acc));
        if (s_req_ready) begin
            q_addr[q_tail % 64] = a; q_data[q_tail % 64] = d; q_tail++;
        end
        @(negedge clk);
        s_req_valid = 1'b0; s_req_write = 1'b0;
    endtask

    task automatic drain_all();
        wr_gnt_en = 1'b1;
        repeat (12) @(negedge clk);
        chk(q_head == q_tail, "R7 everything drained", 32'(q_tail - q_head), 32'd0);
        chk(mem_wr_req == 1'b0, "R7 request drops when empty", 32'(mem_wr_req), 32'd0);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int f0;
        rst_n = 1'b0; s_req_valid = 1'b0; s_req_write = 1'b0;
        s_req_addr = '0; s_req_len = '0; s_req_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state at the ports.
        chk(mem_wr_req == 1'b0, "R8 write buffer empty", 32'(mem_wr_req), 32'd0);
        chk(mem_rd_req == 1'b0, "R8 no fetch", 32'(mem_rd_req), 32'd0);
        chk(s_rsp_valid == 1'b0, "R8 no beat", 32'(s_rsp_valid), 32'd0);
        #1;
        chk(s_req_ready == 1'b1, "R8 read ready after reset", 32'(s_req_ready), 32'd1);

        // R8/R1: first read after reset is a miss.
        rd(32'h0000_0100, 3'd3, 1'b0);

        // R2/R3: every start word and every length on the loaded line.
        for (int i = 0; i < 8; i++)
            for (int l = 0; l < 8; l++)
                rd(32'h0000_0100 + 32'(4*i), 3'(l), 1'b1);

        // R1/R10: misses on other lines, including the top of the address space.
        rd(32'h0000_2000, 3'd2, 1'b0);
        rd(32'hFFFF_FFFC, 3'd1, 1'b0);
        rd(32'h0000_1234, 3'd7, 1'b0);

        // R4/R5: pending write inside the loaded line, then read it as a hit.
        wr_gnt_en = 1'b0;
        wr(32'h0000_1228, 32'hDEAD_BEEF, 1'b1);
        rd(32'h0000_1228, 3'd0, 1'b1);
        rd(32'h0000_1220, 3'd7, 1'b1);
        // R4: pending write to a line that is not loaded, read as a miss.
        wr(32'h0000_3004, 32'h0BAD_F00D, 1'b1);
        rd(32'h0000_3004, 3'd1, 1'b0);
        drain_all();

        // R6/R9: fill the buffer, reject one more, read while full.
        wr_gnt_en = 1'b0;
        for (int i = 0; i < 4; i++) wr(32'h0000_4000 + 32'(4*i), 32'h1111_0000 + 32'(i), 1'b1);
        wr(32'h0000_4010, 32'h2222_2222, 1'b0);
        rd(32'h0000_3008, 3'd2, 1'b1);
        drain_all();

        // R9: a write is taken while a read miss is in progress; reads are refused.
        f0 = fetch_cnt;
        rd_start(32'h0000_5010, 3'd4);
        s_req_valid = 1'b1; s_req_write = 1'b0; s_req_addr = 32'h0000_5000;
        #1;
        chk(s_req_ready == 1'b0, "R9 read refused while busy", 32'(s_req_ready), 32'd0);
        s_req_write = 1'b1; s_req_addr = 32'h0000_5014; s_req_wdata = 32'h5555_AAAA;
        #1;
        chk(s_req_ready == 1'b1, "R9 write accepted while read busy", 32'(s_req_ready), 32'd1);
        q_addr[q_tail % 64] = 32'h0000_5014; q_data[q_tail % 64] = 32'h5555_AAAA; q_tail++;
        @(negedge clk);
        s_req_valid = 1'b0; s_req_write = 1'b0;
        rd_collect(32'h0000_5010, 3'd4, 1'b0, f0);
        drain_all();

        // R8: reset mid-life empties the buffer and forgets the line.
        wr_gnt_en = 1'b0;
        wr(32'h0000_6000, 32'h6666_0000, 1'b1);
        wr(32'h0000_6004, 32'h6666_0001, 1'b1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        q_head = q_tail;
        @(negedge clk);
        chk(mem_wr_req == 1'b0, "R8 reset empties write buffer", 32'(mem_wr_req), 32'd0);
        wr_gnt_en = 1'b1;
        rd(32'h0000_5018, 3'd0, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule